// File: doc/BRIEF.md
# USB Link Power-Management L1 Sleep Controller (Host Side)

This block runs the host end of the USB L1 low-power state. It stores the two-bit handshake result of a link power-management transaction. When that result is an acknowledge, it moves from the awake state into sleep. While asleep it drives the PHY suspend line and, if enabled, the deep low-power line, and it raises a sleep status flag. Software confirms that sleep was entered by reading this flag, not by reading the handshake code.

Sleep ends in one of two ways. Line-state activity, meaning a resume started by the attached device, or a remote-wakeup request moves the block into a resume-drive phase. That phase lasts a number of microseconds chosen by a 4-bit programmed code. A reset request or a soft-disconnect request ends sleep or resume at once and returns the block to awake. Resume time is counted on a one-pulse-per-microsecond tick input, so it does not depend on the system clock frequency.

Top module: `lpm_l1_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all outputs are 0. This includes `hs_result`, which reads 00, `cfg_err`, and every state output.
- R2: One cycle after `hs_valid` is high, `hs_result` holds the `hs_code` that was sampled. The codes are 11 = ACK, 10 = NYET, 01 = STALL and 00 = error or no handshake.
- R3: When the block is awake, only an ACK (11) moves it to sleep, and `sleep_sts` reads 1 in the next cycle. NYET, STALL and error leave `sleep_sts` at 0.
- R4: `sleep_sts` is 1 only in the sleep state. It is 0 while resume is driven and 0 while awake.
- R5: `phy_suspend` is 1 only when the block is asleep and `clk_stop_req` is 1. It is 0 while awake, even when `clk_stop_req` is 1.
- R6: `phy_deep_lp` is 1 only when the block is asleep and bit 4 of the stored threshold field (written through `cfg_thres[4]`) is 1.
- R7: In sleep, `line_activity` or `wake_req` sets `resume_drive` to 1 in the next cycle. In that same cycle, `phy_suspend` and `phy_deep_lp` are 0.
- R8: Resume drive lasts exactly 60 + 75·c microsecond ticks, where c is the stored code in threshold bits [3:0] and c is 0 to 12. `resume_drive` falls in the cycle after the last counted tick, and the block is then awake.
- R9: Codes 13, 14 and 15 drive resume for the code-12 time of 960 ticks. Writing such a code sets `cfg_err`, which stays at 1 until `rst_n` is asserted.
- R10: `reset_req` or `disc_req` in sleep or during resume drive returns the block to awake in the next cycle. No further resume is driven. These requests take priority over `line_activity` and `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| line_activity | input | 1 | Line-state activity seen on the bus (device resume) |
| hs_valid | input | 1 | Handshake result of an LPM transaction is present |
| hs_code | input | 2 | Handshake result code (11 ACK, 10 NYET, 01 STALL, 00 error) |
| cfg_we | input | 1 | Write strobe for the threshold field |
| cfg_thres | input | 5 | Threshold field: bit 4 enables deep low-power, bits [3:0] set the resume code |
| clk_stop_req | input | 1 | Software request to stop the PHY clock |
| wake_req | input | 1 | Remote-wakeup signaling request |
| reset_req | input | 1 | Port reset request |
| disc_req | input | 1 | Soft-disconnect request |
| hs_result | output | 2 | Last recorded handshake code |
| sleep_sts | output | 1 | 1 while in the sleep state |
| phy_suspend | output | 1 | PHY suspend drive |
| phy_deep_lp | output | 1 | PHY deep low-power drive |
| resume_drive | output | 1 | Resume signaling is being driven |
| cfg_err | output | 1 | Sticky flag: an invalid resume code was written |

## Verification
The bench changes inputs on the falling edge and samples on the following falling edge. Because every state register and capture register is one flop away from its inputs, the handshake capture, sleep entry, resume start, abort and error flag are all checked one cycle after their stimulus. The suspend and deep low-power lines are combinational from the state and the request, so they are sampled in the same half-cycle that the state is read. Resume length is checked by counting ticks: the bench drives a random tick pattern, counts each tick it applies while it sees `resume_drive` high, and compares the total with 60 + 75·min(c, 12) at the first sample where `resume_drive` is low.

// File: rtl/lpm_pkg.sv
// Package: shared state type and handshake code values for the L1 controller.
// Assumes: codes are two bits wide and match the link handshake encoding.
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_RESUME = 2'd2
    } lpm_state_t;

    localparam logic [1:0] HS_ACK   = 2'b11;
    localparam logic [1:0] HS_NYET  = 2'b10;
    localparam logic [1:0] HS_STALL = 2'b01;
    localparam logic [1:0] HS_ERR   = 2'b00;
endpackage

// File: rtl/lpm_cfg.sv
// Module: lpm_cfg
// Holds the threshold field and the last handshake result, and flags
// invalid resume codes with a sticky error bit.
// Assumes: cfg_we and hs_valid are single-cycle strobes in the clk domain.
module lpm_cfg #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W:0]   cfg_thres,
    input  logic              hs_valid,
    input  logic [1:0]        hs_code,
    output logic [CODE_W:0]   thres_q,
    output logic [1:0]        hs_result,
    output logic              cfg_err
);
    logic code_bad;
    assign code_bad = (int'(cfg_thres[CODE_W-1:0]) > MAX_CODE);

    // Threshold field register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      thres_q <= '0;
        else if (cfg_we) thres_q <= cfg_thres;
    end

    // Handshake result capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        hs_result <= 2'b00;
        else if (hs_valid) hs_result <= hs_code;
    end

    // Sticky invalid-code flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cfg_err <= 1'b0;
        else if (cfg_we && code_bad) cfg_err <= 1'b1;
    end

    p_hs_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> (hs_result == $past(hs_code)));
    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && code_bad) |=> cfg_err);
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/lpm_resume_timer.sv
// Module: lpm_resume_timer
// Counts microsecond ticks during resume drive and signals the final tick.
// Duration is BASE_US + STEP_US * code, with codes above MAX_CODE clamped.
// Assumes: the duration is latched while idle and held for the whole drive.
module lpm_resume_timer #(
    parameter int CODE_W   = 4,
    parameter int BASE_US  = 60,
    parameter int STEP_US  = 75,
    parameter int MAX_CODE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              us_tick,
    input  logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int MAX_US = BASE_US + STEP_US * MAX_CODE;
    localparam int CNT_W  = $clog2(MAX_US + 1);

    logic [CNT_W-1:0] dur_next;
    logic [CNT_W-1:0] dur_q;
    logic [CNT_W-1:0] cnt;
    int               code_c;

    // Clamp the code and compute the drive time in ticks.
    always_comb begin
        code_c   = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        dur_next = CNT_W'(BASE_US + STEP_US * code_c);
    end

    // Latch the duration while idle so it is fixed during a drive.
    always_ff @(posedge clk) begin
        if (!rst_n)       dur_q <= CNT_W'(BASE_US);
        else if (!active) dur_q <= dur_next;
    end

    // Tick counter, cleared whenever resume is not being driven.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (us_tick)      cnt <= cnt + 1'b1;
    end

    assign done = active && us_tick && (cnt == dur_q - 1'b1);

    p_cnt_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < dur_q));
    p_dur_capped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dur_q) <= MAX_US);
endmodule

// File: rtl/lpm_fsm.sv
// Module: lpm_fsm
// L1 state sequencer: awake, sleep on ACK, resume drive on wake, back to awake.
// Assumes: reset and disconnect requests outrank wake events.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_valid,
    input  logic [1:0] hs_code,
    input  logic       line_activity,
    input  logic       wake_req,
    input  logic       reset_req,
    input  logic       disc_req,
    input  logic       resume_done,
    output lpm_state_t state
);
    lpm_state_t nxt;
    logic       abort;
    logic       wake;

    assign abort = reset_req || disc_req;
    assign wake  = line_activity || wake_req;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_AWAKE:  if (hs_valid && hs_code == HS_ACK) nxt = ST_SLEEP;
            ST_SLEEP:  if (abort) nxt = ST_AWAKE;
                       else if (wake) nxt = ST_RESUME;
            ST_RESUME: if (abort || resume_done) nxt = ST_AWAKE;
            default:   nxt = ST_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= nxt;
    end

    p_enter_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_AWAKE) |->
            ($past(hs_valid) && $past(hs_code) == HS_ACK));
    p_wake_starts_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !abort && wake) |=> (state == ST_RESUME));
    p_abort_to_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_AWAKE && abort) |=> (state == ST_AWAKE));
endmodule

// File: rtl/lpm_l1_ctrl.sv
// Module: lpm_l1_ctrl (top)
// Host-side L1 sleep controller: records the handshake, sequences sleep and
// resume, and drives the PHY suspend, deep low-power and resume lines.
// Assumes: us_tick is a one-cycle pulse once per microsecond.
module lpm_l1_ctrl
    import lpm_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int BASE_US  = 60,
    parameter int STEP_US  = 75,
    parameter int MAX_CODE = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            line_activity,
    input  logic            hs_valid,
    input  logic [1:0]      hs_code,
    input  logic            cfg_we,
    input  logic [CODE_W:0] cfg_thres,
    input  logic            clk_stop_req,
    input  logic            wake_req,
    input  logic            reset_req,
    input  logic            disc_req,
    output logic [1:0]      hs_result,
    output logic            sleep_sts,
    output logic            phy_suspend,
    output logic            phy_deep_lp,
    output logic            resume_drive,
    output logic            cfg_err
);
    logic [CODE_W:0] thres_q;
    logic            resume_done;
    lpm_state_t      state;

    lpm_cfg #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_thres (cfg_thres),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code),
        .thres_q   (thres_q),
        .hs_result (hs_result),
        .cfg_err   (cfg_err)
    );

    lpm_resume_timer #(
        .CODE_W(CODE_W), .BASE_US(BASE_US), .STEP_US(STEP_US), .MAX_CODE(MAX_CODE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (resume_drive),
        .us_tick (us_tick),
        .code    (thres_q[CODE_W-1:0]),
        .done    (resume_done)
    );

    lpm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code),
        .line_activity (line_activity),
        .wake_req      (wake_req),
        .reset_req     (reset_req),
        .disc_req      (disc_req),
        .resume_done   (resume_done),
        .state         (state)
    );

    // Output decode from the state and the live requests.
    always_comb begin
        sleep_sts    = (state == ST_SLEEP);
        resume_drive = (state == ST_RESUME);
        phy_suspend  = sleep_sts && clk_stop_req;
        phy_deep_lp  = sleep_sts && thres_q[CODE_W];
    end

    p_quiet_in_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_drive |-> (!phy_suspend && !phy_deep_lp && !sleep_sts));
    p_no_deep_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_sts |-> !phy_deep_lp);
    p_no_suspend_awake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_sts |-> !phy_suspend);
endmodule

// File: tb/tb_lpm_l1_ctrl.sv
module tb_lpm_l1_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, us_tick, line_activity, hs_valid, cfg_we;
    logic       clk_stop_req, wake_req, reset_req, disc_req;
    logic [1:0] hs_code;
    logic [4:0] cfg_thres;
    logic [1:0] hs_result;
    logic       sleep_sts, phy_suspend, phy_deep_lp, resume_drive, cfg_err;

    int tests  = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_l1_ctrl dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_activity(line_activity),
        .hs_valid(hs_valid), .hs_code(hs_code), .cfg_we(cfg_we), .cfg_thres(cfg_thres),
        .clk_stop_req(clk_stop_req), .wake_req(wake_req), .reset_req(reset_req),
        .disc_req(disc_req), .hs_result(hs_result), .sleep_sts(sleep_sts),
        .phy_suspend(phy_suspend), .phy_deep_lp(phy_deep_lp),
        .resume_drive(resume_drive), .cfg_err(cfg_err)
    );

    function automatic int exp_dur(input int c);
        return (c > 12) ? 960 : 60 + 75 * c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [4:0] v);
        cfg_we = 1'b1; cfg_thres = v; cyc(); cfg_we = 1'b0;
    endtask

    task automatic send_hs(input logic [1:0] c);
        hs_valid = 1'b1; hs_code = c; cyc(); hs_valid = 1'b0;
    endtask

    // Wake from sleep, then count ticks applied while resume is driven.
    task automatic run_resume(input bit use_wake, input int code, input string req);
        int n = 0;
        int guard = 0;
        if (use_wake) wake_req = 1'b1; else line_activity = 1'b1;
        cyc();
        wake_req = 1'b0; line_activity = 1'b0;
        check(resume_drive == 1'b1, "R7 resume start", resume_drive, 1);
        check(!phy_suspend && !phy_deep_lp, "R7 suspend off", {phy_suspend, phy_deep_lp}, 0);
        check(sleep_sts == 1'b0, "R4 no sleep in resume", sleep_sts, 0);
        while (resume_drive && guard < 3000) begin
            logic t;
            t = 1'($urandom % 2);
            if (t) n++;
            us_tick = t;
            cyc();
            guard++;
        end
        us_tick = 1'b0;
        check(n == exp_dur(code), req, n, exp_dur(code));
        check(!resume_drive && !sleep_sts, "R8 back awake", {resume_drive, sleep_sts}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 0; us_tick = 0; line_activity = 0; hs_valid = 0; hs_code = 0;
        cfg_we = 0; cfg_thres = 0; clk_stop_req = 0; wake_req = 0;
        reset_req = 0; disc_req = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        check(hs_result == 0 && !cfg_err, "R1 regs", {hs_result, cfg_err}, 0);
        check(!sleep_sts && !phy_suspend && !phy_deep_lp && !resume_drive, "R1 state",
              {sleep_sts, phy_suspend, phy_deep_lp, resume_drive}, 0);

        // R2/R3: non-ACK codes are recorded and keep the block awake
        for (int c = 0; c < 3; c++) begin
            send_hs(2'(c));
            check(hs_result == 2'(c), "R2 capture", hs_result, c);
            check(sleep_sts == 1'b0, "R3 non-ACK stays awake", sleep_sts, 0);
        end

        // R5: clock-stop request while awake has no effect
        clk_stop_req = 1'b1; cyc();
        check(phy_suspend == 1'b0, "R5 awake no suspend", phy_suspend, 0);

        // R3/R2: ACK enters sleep; R5 suspend follows clock-stop
        send_hs(2'b11);
        check(hs_result == 2'b11, "R2 capture ACK", hs_result, 3);
        check(sleep_sts == 1'b1, "R3 ACK sleeps", sleep_sts, 1);
        check(phy_suspend == 1'b1, "R5 suspend with stop", phy_suspend, 1);
        clk_stop_req = 1'b0; cyc();
        check(phy_suspend == 1'b0, "R5 suspend without stop", phy_suspend, 0);
        check(phy_deep_lp == 1'b0, "R6 deep off", phy_deep_lp, 0);
        run_resume(1'b0, 0, "R8 code 0 duration");

        // R8: all valid codes, cfg_err stays clear; R6 deep follows bit 4
        for (int c = 1; c <= 12; c++) begin
            logic d;
            d = 1'($urandom % 2);
            write_cfg({d, 4'(c)});
            check(cfg_err == 1'b0, "R9 valid code no error", cfg_err, 0);
            clk_stop_req = 1'b1;
            send_hs(2'b11);
            check(phy_deep_lp == d, "R6 deep low-power", phy_deep_lp, d);
            run_resume(1'($urandom % 2), c, "R8 duration");
            clk_stop_req = 1'b0;
        end

        // R9: invalid codes clamp and set the sticky flag
        for (int c = 13; c <= 15; c++) begin
            write_cfg(5'(c));
            check(cfg_err == 1'b1, "R9 error set", cfg_err, 1);
            send_hs(2'b11);
            run_resume(1'b0, c, "R9 clamped duration");
        end
        write_cfg(5'd2);
        check(cfg_err == 1'b1, "R9 error sticky", cfg_err, 1);

        // R10: reset request in sleep outranks line activity
        send_hs(2'b11);
        reset_req = 1'b1; line_activity = 1'b1; cyc();
        reset_req = 1'b0; line_activity = 1'b0;
        check(!sleep_sts && !resume_drive, "R10 reset from sleep", {sleep_sts, resume_drive}, 0);

        // R10: disconnect during resume drive ends it
        send_hs(2'b11);
        wake_req = 1'b1; cyc(); wake_req = 1'b0;
        us_tick = 1'b1; repeat (5) cyc(); us_tick = 1'b0;
        check(resume_drive == 1'b1, "R8 still driving", resume_drive, 1);
        disc_req = 1'b1; cyc(); disc_req = 1'b0;
        check(!resume_drive && !sleep_sts, "R10 disconnect in resume", {resume_drive, sleep_sts}, 0);

        // R3: ACK arriving outside the awake state does not restart sleep
        send_hs(2'b11);
        line_activity = 1'b1; cyc(); line_activity = 1'b0;
        send_hs(2'b11);
        check(resume_drive == 1'b1 && !sleep_sts, "R3 ACK in resume ignored",
              {resume_drive, sleep_sts}, 2);
        reset_req = 1'b1; cyc(); reset_req = 1'b0;

        // Random mix of configurations and wake sources
        for (int i = 0; i < 8; i++) begin
            int c;
            c = int'($urandom % 16);
            write_cfg({1'b0, 4'(c)});
            send_hs(2'(3 - ($urandom % 2)));
            if (sleep_sts) run_resume(1'($urandom % 2), c, "R8 random duration");
            else check(hs_result == 2'b10, "R3 NYET awake", hs_result, 2);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule